// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block receives one load request from a 32-lane warp and reduces it to the fewest aligned 128-byte memory transactions that cover every active lane. Each lane presents a byte address and an active flag, and each active lane reads one naturally aligned 4-byte word. Lanes are grouped by the 128-byte segment they touch, not by exact address. Identical addresses therefore collapse into one transaction, and a misaligned run splits only where it crosses a segment boundary.

The request is taken when the block is idle. The block then issues one transaction per distinct segment over a valid/ready channel. Each transaction carries the segment base and the set of lanes it serves. When the last transaction is taken, a one-cycle done pulse marks the final transaction count. The useful byte count (active lanes × 4) is also reported, so that efficiency can be computed as useful bytes / (transactions × 128).

Top module: `warp_coalescer`

## Requirements
- R1: Thirty-two active lanes reading consecutive words from a 128-byte-aligned base produce exactly one transaction. Its base is that address and its lane mask is all ones.
- R2: A lane stride of 128 bytes produces 32 transactions. Transaction k has mask bit k alone set, and its base is lane k's address.
- R3: A 24-byte lane stride from an aligned base produces 6 transactions.
- R4: When all active lanes give the same address, the block sends one transaction whose mask holds every active lane. Its base is the address with bits [6:0] cleared.
- R5: Consecutive words starting 4 bytes past a segment boundary produce two transactions. The first has mask 0x7FFFFFFF on the lower segment, and the second has mask 0x80000000 on the next segment.
- R6: Inactive lanes never appear in any mask and add nothing to the useful byte count. A request with no active lanes produces no transaction, and done_o is high in the cycle after acceptance with a count of 0.
- R7: Transactions go out in ascending order of the lowest unserved active lane. Each mask holds every unserved active lane in the same segment, and no lane is served twice.
- R8: While txn_valid_o is high and txn_ready_i is low, txn_base_o and txn_mask_o hold steady. Every base has bits [6:0] at zero.
- R9: req_ready_o is low from the cycle after a non-empty request is accepted until its last transaction is taken. Transactions start only after an accepted request.
- R10: done_o pulses for one cycle, the cycle after the final transaction handshake. txn_count_o then equals the number of transactions sent. useful_bytes_o equals 4 × active lanes from the cycle after acceptance. Both values hold until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Warp request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_addr_i | input | 1024 | Lane byte addresses, lane i in bits [32i+31:32i] |
| req_active_i | input | 32 | Lane active flags, bit i for lane i |
| txn_valid_o | output | 1 | Transaction present |
| txn_ready_i | input | 1 | Memory side takes the transaction |
| txn_base_o | output | 32 | 128-byte-aligned segment base |
| txn_mask_o | output | 32 | Lanes served by this transaction |
| done_o | output | 1 | One-cycle pulse after the last transaction |
| txn_count_o | output | 6 | Transactions issued for the current request |
| useful_bytes_o | output | 8 | Useful bytes of the current request |

## Verification
The assertions take for granted that every lane address is word aligned, so a lane never spans two segments. They also assume req_valid_i is raised only while the block is idle. The stimulus builds every address as a word multiple and waits for each done pulse before presenting the next request. The memory-side ready follows an irregular stall pattern, so that transactions are held across stalls.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int unsigned LANES_D    = 32;
  localparam int unsigned ADDR_W_D   = 32;
  localparam int unsigned SEG_BYTES_D = 128;
  localparam int unsigned WORD_BYTES_D = 4;
endpackage

// File: rtl/coal_lead_pick.sv
module coal_lead_pick #(
  parameter int unsigned N  = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match #(
  parameter int unsigned N     = 32,
  parameter int unsigned SEG_W = 25
) (
  input  logic [N-1:0][SEG_W-1:0] segs_i,
  input  logic [SEG_W-1:0]        lead_i,
  input  logic [N-1:0]            pend_i,
  output logic [N-1:0]            mask_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    assign mask_o[g] = pend_i[g] && (segs_i[g] == lead_i);
  end
endmodule

// File: rtl/coal_popcount.sv
module coal_popcount #(
  parameter int unsigned N  = 32,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(bits_i[i]);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int unsigned LANES      = LANES_D,
  parameter int unsigned ADDR_W     = ADDR_W_D,
  parameter int unsigned SEG_BYTES  = SEG_BYTES_D,
  parameter int unsigned WORD_BYTES = WORD_BYTES_D,
  localparam int unsigned SEG_LSB = $clog2(SEG_BYTES),
  localparam int unsigned SEG_W   = ADDR_W - SEG_LSB,
  localparam int unsigned IW      = $clog2(LANES),
  localparam int unsigned CW      = $clog2(LANES + 1),
  localparam int unsigned UW      = $clog2(LANES * WORD_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]        req_active_i,
  output logic                    txn_valid_o,
  input  logic                    txn_ready_i,
  output logic [ADDR_W-1:0]       txn_base_o,
  output logic [LANES-1:0]        txn_mask_o,
  output logic                    done_o,
  output logic [CW-1:0]           txn_count_o,
  output logic [UW-1:0]           useful_bytes_o
);

  logic                        busy_q, done_q;
  logic [LANES-1:0]            pend_q;
  logic [LANES-1:0][SEG_W-1:0] seg_q, seg_in;
  logic [CW-1:0]               count_q, pop_cnt;
  logic [UW-1:0]               useful_q;
  logic [IW-1:0]               lead_idx;
  logic                        lead_any;
  logic [SEG_W-1:0]            lead_seg;
  logic [LANES-1:0]            match;
  logic                        accept, fire, last;

  for (genvar g = 0; g < LANES; g++) begin : g_seg
    assign seg_in[g] = req_addr_i[g*ADDR_W+SEG_LSB +: SEG_W];
  end

  coal_popcount #(.N(LANES)) u_pop (
    .bits_i (req_active_i),
    .cnt_o  (pop_cnt)
  );

  coal_lead_pick #(.N(LANES)) u_lead (
    .req_i (pend_q),
    .idx_o (lead_idx),
    .any_o (lead_any)
  );

  assign lead_seg = seg_q[lead_idx];

  coal_seg_match #(.N(LANES), .SEG_W(SEG_W)) u_match (
    .segs_i (seg_q),
    .lead_i (lead_seg),
    .pend_i (pend_q),
    .mask_o (match)
  );

  assign req_ready_o    = !busy_q;
  assign accept         = req_valid_i && req_ready_o;
  assign txn_valid_o    = busy_q && lead_any;
  assign txn_base_o     = {lead_seg, {SEG_LSB{1'b0}}};
  assign txn_mask_o     = match;
  assign fire           = txn_valid_o && txn_ready_i;
  assign last           = (pend_q & ~match) == '0;
  assign done_o         = done_q;
  assign txn_count_o    = count_q;
  assign useful_bytes_o = useful_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pend_q   <= '0;
      seg_q    <= '0;
      count_q  <= '0;
      useful_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pend_q   <= req_active_i;
        seg_q    <= seg_in;
        count_q  <= '0;
        useful_q <= UW'(32'(pop_cnt) * WORD_BYTES);
        busy_q   <= |req_active_i;
        done_q   <= ~|req_active_i;
      end else if (fire) begin
        pend_q  <= pend_q & ~match;
        count_q <= count_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R7: each issued mask is non-empty and disjoint from the next one
  p_mask_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> txn_mask_o != '0);
  p_lane_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !txn_valid_o || ((txn_mask_o & $past(txn_mask_o)) == '0));
  // R8: stalled transaction holds
  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_base_o) && $stable(txn_mask_o));
  // R9: transactions begin only after an accepted request
  p_start_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txn_valid_o) |-> $past(req_valid_i && req_ready_o));
  // R10: done marks an idle channel and a bounded count
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !txn_valid_o && txn_count_o <= CW'(LANES));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [LANES*32-1:0] req_addr_i = '0;
  logic [LANES-1:0]  req_active_i = '0;
  logic              txn_valid_o;
  logic              txn_ready_i = 1'b0;
  logic [31:0]       txn_base_o;
  logic [LANES-1:0]  txn_mask_o;
  logic              done_o;
  logic [5:0]        txn_count_o;
  logic [7:0]        useful_bytes_o;

  warp_coalescer u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, failures = 0;
  int cyc = 0;
  int done_seen = 0;
  int exp_count = 0;
  int exp_useful = 0;
  string cur_req = "R1";
  logic [31:0] exp_base_q[$];
  logic [31:0] exp_mask_q[$];
  logic [31:0] a [LANES];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // driver: builds expectation from the requirements, then presents the request
  task automatic run_req(input string req, input logic [31:0] act);
    logic [31:0] served = '0;
    int start, n = 0, pop = 0;
    exp_base_q.delete();
    exp_mask_q.delete();
    for (int i = 0; i < LANES; i++) begin
      if (act[i]) pop++;
      if (act[i] && !served[i]) begin
        logic [31:0] m = '0;
        for (int j = i; j < LANES; j++)
          if (act[j] && (a[j] >> 7) == (a[i] >> 7)) m[j] = 1'b1;
        served |= m;
        exp_base_q.push_back({a[i][31:7], 7'd0});
        exp_mask_q.push_back(m);
        n++;
      end
    end
    exp_count = n;
    exp_useful = pop * 4;
    cur_req = req;
    start = done_seen;
    @(negedge clk_i);
    for (int i = 0; i < LANES; i++) req_addr_i[i*32 +: 32] = a[i];
    req_active_i = act;
    req_valid_i = 1'b1;
    chk(req_ready_o == 1'b1, "R9", "ready while idle", req_ready_o, 1);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(useful_bytes_o == 8'(exp_useful), "R10", "useful bytes", useful_bytes_o, exp_useful);
    if (n == 0) begin
      chk(done_o == 1'b1, "R6", "empty request done", done_o, 1);
      chk(txn_valid_o == 1'b0, "R6", "empty request no txn", txn_valid_o, 0);
    end else begin
      chk(req_ready_o == 1'b0, "R9", "busy not ready", req_ready_o, 0);
    end
    while (done_seen == start) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(txn_count_o == 6'(n), "R10", "count held", txn_count_o, n);
    chk(useful_bytes_o == 8'(exp_useful), "R10", "useful held", useful_bytes_o, exp_useful);
    chk(done_o == 1'b0, "R10", "done single pulse", done_o, 0);
  endtask

  // monitor: stall pattern on ready, compare handshakes and done
  logic [31:0] prev_base, prev_mask;
  logic prev_stall = 1'b0;
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (prev_stall && txn_valid_o)
        chk(txn_base_o == prev_base && txn_mask_o == prev_mask, "R8", "stall hold",
            txn_mask_o, prev_mask);
      txn_ready_i = ((cyc % 5) != 2) && ((cyc % 7) != 3);
      #1;
      if (txn_valid_o) begin
        chk(txn_base_o[6:0] == 7'd0, "R8", "base aligned", txn_base_o, {txn_base_o[31:7], 7'd0});
        if (txn_ready_i) begin
          if (exp_base_q.size() == 0) begin
            chk(1'b0, cur_req, "unexpected txn", txn_mask_o, 0);
          end else begin
            logic [31:0] eb, em;
            eb = exp_base_q.pop_front();
            em = exp_mask_q.pop_front();
            chk(txn_base_o == eb, cur_req, "txn base", txn_base_o, eb);
            chk(txn_mask_o == em, cur_req, "txn mask", txn_mask_o, em);
          end
        end
      end
      prev_stall = txn_valid_o && !txn_ready_i;
      prev_base = txn_base_o;
      prev_mask = txn_mask_o;
      if (done_o) begin
        chk(txn_count_o == 6'(exp_count), cur_req, "final count", txn_count_o, exp_count);
        chk(exp_base_q.size() == 0, cur_req, "missing txns", exp_base_q.size(), 0);
        done_seen++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "R10", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(txn_valid_o == 1'b0, "R9", "reset txn_valid", txn_valid_o, 0);
    chk(req_ready_o == 1'b1, "R9", "reset ready", req_ready_o, 1);
    chk(done_o == 1'b0, "R10", "reset done", done_o, 0);

    for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 32'(4*i);
    run_req("R1", '1);
    for (int i = 0; i < LANES; i++) a[i] = 32'h10000 + 32'(128*i);
    run_req("R2", '1);
    for (int i = 0; i < LANES; i++) a[i] = 32'h2000 + 32'(24*i);
    run_req("R3", '1);
    for (int i = 0; i < LANES; i++) a[i] = 32'h3454;
    run_req("R4", '1);
    for (int i = 0; i < LANES; i++) a[i] = 32'h4004 + 32'(4*i);
    run_req("R5", '1);
    for (int i = 0; i < LANES; i++) a[i] = 32'h20000 + 32'(128*i);
    run_req("R6", 32'h5A5A_0F0F);
    run_req("R6", 32'h0);
    for (int i = 0; i < LANES; i++)
      a[i] = (i % 2 == 1) ? 32'h8000 + 32'(4*i) : 32'h9000 + 32'(4*i);
    run_req("R7", '1);
    for (int i = 0; i < LANES; i++) a[i] = 32'h6000 + 32'(((i * 7) % 5) * 128) + 32'(4*i);
    run_req("R7", 32'hFFF0_FFFE);
    finish_run();
  end
endmodule